// File: doc/BRIEF.md
# Dual-Function DMA Request/Acknowledge Engine

This block drives the request/acknowledge handshake between an external system DMA controller and two independent on-chip functions, a host side (side 0) and a device side (side 1). Each side has its own configuration byte. The byte sets the transfer direction, which internal buffer is addressed, an enable, the number of transfers per request (burst) and whether a byte counter limits the transfer. When the counter is in use, a transfer ends once the programmed byte count has been moved. The side then drops its enable and raises a sticky end-of-transfer flag. Interrupt output 0 carries the host-side flag and output 1 carries the device-side flag, each gated by its own enable.

Each side normally owns one request/acknowledge pin pair, and the polarity of each pin can be programmed. A merge option carries both sides over pair 0 for systems that have only one DMA channel free. In merged mode the request is forced active high and the acknowledge active low, whatever the polarity settings. A fixed-priority arbiter favours the host side and hands the channel over only between bursts. The block's edge has no data path. One acknowledged transfer moves one 16-bit word, and a per-side strobe with direction and buffer-select outputs tells the local buffer logic when to move it. These are plain level and pulse signals with no back-pressure, because the external controller paces the transfers through the acknowledge.

Register writes use a single-cycle write strobe with an address and data. The addresses are:

| Address | Register |
|---------|----------|
| 0 | host configuration |
| 1 | host byte count |
| 2 | device configuration |
| 3 | device byte count |
| 4 | end-of-transfer flag clear (write 1 to clear; bit 0 host, bit 1 device) |
| 5 | interrupt enable (bit 0 host, bit 1 device) |
| 6 | hardware configuration |

Configuration byte layout: bit 0 direction (1 = read), bits 3:1 buffer select, bit 4 enable, bits 6:5 burst code, bit 7 counter enable.

Hardware configuration bits: bit 0 merge, bit 1 request 0 active high, bit 2 acknowledge 0 active high, bit 3 request 1 active high, bit 4 acknowledge 1 active high. Its reset value is 0x0A.

Top module: `dma_hs_engine`

## Requirements
- R1: After reset both request pins sit at their inactive level, which is low with the reset polarities, and no strobe or interrupt is active.
- R2: Writing a configuration byte with bit 4 set asserts that side's request one clock after the write is taken, when the side may start.
- R3: The burst code in bits 6:5 gives the transfers per request: 0→1, 1→4, 2→8, 3→16. A request holds until its burst's last acknowledge. It then drops for at least one cycle and reasserts while work remains, so a transfer of X words shows exactly ceil(X/burst) request pulses.
- R4: With bit 7 set, each acknowledge takes 2 from the byte count, or 1 when one byte remains, so N bytes take ceil(N/2) transfers. When the count runs out the request stops and the enable bit clears, so reloading the count alone starts nothing. A count of 0 raises no request.
- R5: Running out of the count sets a sticky flag. Writing 1 to its bit at address 4 clears it. An interrupt output is high exactly while its flag and its enable bit at address 5 are both set.
- R6: Clearing the enable during a burst lets that burst finish, then stops requesting, and sets no end-of-transfer flag.
- R7: With bit 7 clear, bursts repeat for as long as the enable stays set.
- R8: Outside merged mode, hardware configuration bits 1 to 4 set the active level of each request and acknowledge pin.
- R9: In merged mode both sides use pin pair 0, with the request active high and the acknowledge active low. Request pin 1 rests at its inactive level, and acknowledge pin 1 is ignored.
- R10: In merged mode at most one side requests at a time, the host side wins when both are waiting, and the owner never changes inside a burst.
- R11: Interrupt output 0 carries only the host-side flag and output 1 only the device-side flag.
- R12: `xfer_stb[i]` is high in each cycle in which side i's acknowledge is taken, and `xfer_rd[i]` and `xfer_buf[3i+2:3i]` show side i's direction and buffer-select bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| dreq_pin | output | 2 | DMA request pins, one per channel |
| dack_pin | input | 2 | DMA acknowledge pins, one per channel |
| xfer_stb | output | 2 | Per-side strobe for one taken transfer |
| xfer_rd | output | 2 | Per-side direction (1 = read) |
| xfer_buf | output | 6 | Per-side buffer select, 3 bits each |
| irq | output | 2 | Interrupt outputs (0 host, 1 device) |

## Verification
The hardest case to reach from the ports is the arbiter's no-preemption rule. The host side must become ready while the device side is inside a burst on the merged channel. The stimulus gets there by polling the device strobe count until a burst is under way and only then enabling the host. It then checks that every request pulse carried strobes from one side only and that the host flag rose before the device flag. The mid-burst disable is reached the same way. The bench waits for a known acknowledge count inside the third 16-transfer burst and then clears the enable, so the expected total is exactly three bursts.

// File: rtl/dma_hs_pkg.sv
`timescale 1ns/1ps
package dma_hs_pkg;
  // configuration byte; the packed order puts cnt_en at bit 7 and rd at bit 0
  typedef struct packed {
    logic       cnt_en;
    logic [1:0] burst;
    logic       en;
    logic [2:0] buf_sel;
    logic       rd;
  } dma_cfg_t;

  localparam int NSIDE  = 2;
  localparam int BEAT_W = 5;

  localparam logic [2:0] A_STAT = 3'd4;
  localparam logic [2:0] A_IEN  = 3'd5;
  localparam logic [2:0] A_HW   = 3'd6;

  // merge=0, req0 high, ack0 low, req1 high, ack1 low
  localparam logic [4:0] HW_RST = 5'b01010;

  function automatic logic [BEAT_W-1:0] burst_beats(input logic [1:0] code);
    case (code)
      2'd0:    return BEAT_W'(1);
      2'd1:    return BEAT_W'(4);
      2'd2:    return BEAT_W'(8);
      default: return BEAT_W'(16);
    endcase
  endfunction
endpackage

// File: rtl/dma_side_seq.sv
`timescale 1ns/1ps
module dma_side_seq
  import dma_hs_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             cnt_en,
  input  logic [1:0]       burst,
  input  logic             cnt_load,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             start_ok,
  input  logic             ack,
  output logic             req,
  output logic             want,
  output logic             xfer,
  output logic             done
);
  logic [CNT_W-1:0]  bytes_q;
  logic [BEAT_W-1:0] beat_q;
  logic              active_q;
  logic              gap_q;
  logic              last_beat;
  logic              last_byte;

  assign last_beat = (beat_q == burst_beats(burst) - BEAT_W'(1));
  assign last_byte = cnt_en && (bytes_q <= CNT_W'(2));
  assign want      = en && (!cnt_en || (bytes_q != '0));
  assign xfer      = active_q && ack;
  assign done      = xfer && last_byte;
  assign req       = active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bytes_q  <= '0;
      beat_q   <= '0;
      active_q <= 1'b0;
      gap_q    <= 1'b0;
    end else begin
      gap_q <= 1'b0;
      if (cnt_load) begin
        bytes_q <= cnt_val;
      end else if (xfer && cnt_en && (bytes_q != '0)) begin
        bytes_q <= bytes_q - ((bytes_q == CNT_W'(1)) ? CNT_W'(1) : CNT_W'(2));
      end
      if (!active_q) begin
        if (want && start_ok && !gap_q) begin
          active_q <= 1'b1;
          beat_q   <= '0;
        end
      end else if (ack) begin
        if (last_beat || last_byte) begin
          active_q <= 1'b0;
          gap_q    <= 1'b1;
        end else begin
          beat_q <= beat_q + BEAT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/dma_chan_mux.sv
`timescale 1ns/1ps
module dma_chan_mux (
  input  logic       merge,
  input  logic       req0_hi,
  input  logic       ack0_hi,
  input  logic       req1_hi,
  input  logic       ack1_hi,
  input  logic [1:0] req,
  input  logic [1:0] want,
  input  logic [1:0] dack_pin,
  output logic [1:0] dreq_pin,
  output logic [1:0] ack,
  output logic [1:0] start_ok
);
  always_comb begin
    if (merge) begin
      dreq_pin[0] = req[0] | req[1];
      dreq_pin[1] = ~req1_hi;
      ack         = {2{~dack_pin[0]}};
      // host first; device only when host neither owns nor waits
      start_ok[0] = want[0] & ~req[1];
      start_ok[1] = want[1] & ~req[0] & ~want[0];
    end else begin
      dreq_pin[0] = req0_hi ? req[0] : ~req[0];
      dreq_pin[1] = req1_hi ? req[1] : ~req[1];
      ack[0]      = ack0_hi ? dack_pin[0] : ~dack_pin[0];
      ack[1]      = ack1_hi ? dack_pin[1] : ~dack_pin[1];
      start_ok    = want;
    end
  end
endmodule

// File: rtl/dma_hs_engine.sv
`timescale 1ns/1ps
module dma_hs_engine
  import dma_hs_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [1:0]        dreq_pin,
  input  logic [1:0]        dack_pin,
  output logic [1:0]        xfer_stb,
  output logic [1:0]        xfer_rd,
  output logic [5:0]        xfer_buf,
  output logic [1:0]        irq
);
  logic [NSIDE-1:0]   req, want, ack, start_ok, done, xfer, eot_q;
  logic [NSIDE-1:0]   ie_q;
  logic [2*NSIDE-1:0] burst_code;
  logic [4:0]         hw_q;
  logic               merge;

  assign merge = hw_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q <= '0;
      hw_q <= HW_RST;
    end else if (reg_we) begin
      if (reg_addr == ADDR_W'(A_IEN)) ie_q <= reg_wdata[NSIDE-1:0];
      if (reg_addr == ADDR_W'(A_HW))  hw_q <= reg_wdata[4:0];
    end
  end

  for (genvar i = 0; i < NSIDE; i++) begin : g_side
    dma_cfg_t cfg_r;
    logic     eot_r;
    logic     cfg_wr;
    logic     cnt_wr;

    assign cfg_wr = reg_we && (reg_addr == ADDR_W'(2 * i));
    assign cnt_wr = reg_we && (reg_addr == ADDR_W'(2 * i + 1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cfg_r    <= '0;
      else if (cfg_wr)   cfg_r    <= dma_cfg_t'(reg_wdata[7:0]);
      else if (done[i])  cfg_r.en <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        eot_r <= 1'b0;
      else if (done[i])  eot_r <= 1'b1;
      else if (reg_we && (reg_addr == ADDR_W'(A_STAT)) && reg_wdata[i]) eot_r <= 1'b0;
    end

    dma_side_seq #(.CNT_W(CNT_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (cfg_r.en),
      .cnt_en   (cfg_r.cnt_en),
      .burst    (cfg_r.burst),
      .cnt_load (cnt_wr),
      .cnt_val  (reg_wdata[CNT_W-1:0]),
      .start_ok (start_ok[i]),
      .ack      (ack[i]),
      .req      (req[i]),
      .want     (want[i]),
      .xfer     (xfer[i]),
      .done     (done[i])
    );

    assign eot_q[i]            = eot_r;
    assign burst_code[2*i +: 2] = cfg_r.burst;
    assign xfer_rd[i]          = cfg_r.rd;
    assign xfer_buf[3*i +: 3]  = cfg_r.buf_sel;
  end

  dma_chan_mux u_mux (
    .merge    (merge),
    .req0_hi  (hw_q[1]),
    .ack0_hi  (hw_q[2]),
    .req1_hi  (hw_q[3]),
    .ack1_hi  (hw_q[4]),
    .req      (req),
    .want     (want),
    .dack_pin (dack_pin),
    .dreq_pin (dreq_pin),
    .ack      (ack),
    .start_ok (start_ok)
  );

  assign xfer_stb = xfer;
  assign irq      = eot_q & ie_q;
endmodule

// File: rtl/dma_hs_checker.sv
`timescale 1ns/1ps
module dma_hs_checker
  import dma_hs_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       merge,
  input logic       dreq1_hi,
  input logic       dreq_pin1,
  input logic [1:0] req,
  input logic [1:0] ack,
  input logic [1:0] done,
  input logic [1:0] eot,
  input logic [1:0] ie,
  input logic [1:0] irq,
  input logic [3:0] burst_code
);
  for (genvar i = 0; i < 2; i++) begin : g_chk
    logic [BEAT_W:0] taken;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                taken <= '0;
      else if (!req[i])          taken <= '0;
      else if (ack[i])           taken <= taken + 1'b1;
    end

    p_burst_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req[i] && ack[i]) |-> (taken < {1'b0, burst_beats(burst_code[2*i +: 2])}));
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req[i] && !ack[i]) |=> req[i]);
    p_done_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done[i] |=> !req[i]);
    p_eot_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done[i] |=> eot[i]);
    p_irq_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !ie[i] |-> !irq[i]);
  end

  p_pin1_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    merge |-> (dreq_pin1 == ~dreq1_hi));
  p_one_owner_r10: assert property (@(posedge clk) disable iff (!rst_n)
    merge |-> !(req[0] && req[1]));
  p_route_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !eot[1] |-> !irq[1]);
endmodule

bind dma_hs_engine dma_hs_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .merge      (merge),
  .dreq1_hi   (hw_q[3]),
  .dreq_pin1  (dreq_pin[1]),
  .req        (req),
  .ack        (ack),
  .done       (done),
  .eot        (eot_q),
  .ie         (ie_q),
  .irq        (irq),
  .burst_code (burst_code)
);

// File: tb/tb_dma_hs_engine.sv
`timescale 1ns/1ps
module tb_dma_hs_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [1:0]  dreq_pin;
  logic [1:0]  dack_pin = 2'b11;
  logic [1:0]  xfer_stb, xfer_rd, irq;
  logic [5:0]  xfer_buf;

  always #2 clk = ~clk;

  dma_hs_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .dreq_pin(dreq_pin), .dack_pin(dack_pin),
    .xfer_stb(xfer_stb), .xfer_rd(xfer_rd), .xfer_buf(xfer_buf), .irq(irq)
  );

  int total = 0, bad = 0;
  // bench view of the pin polarities and of the external controller
  bit req_hi [2] = '{1'b1, 1'b1};
  bit ack_hi [2] = '{1'b0, 1'b0};
  bit merged_m = 0, garbage1 = 0;
  int ack_pct = 0;
  int acks [2], rises [2], run [2], maxrun [2], stb [2];
  bit prev_act [2];
  int owner = -1, purity_err = 0, both_err = 0, pin1_err = 0;
  int cycle = 0, t_irq0 = -1, t_irq1 = -1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int beats(input int code);
    case (code)
      0: return 1;
      1: return 4;
      2: return 8;
      default: return 16;
    endcase
  endfunction

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  function automatic logic [15:0] mk_cfg(input bit cnt, input int code, input bit en,
                                         input int bsel, input bit rd);
    logic [1:0] c2 = 2'(code);
    logic [2:0] b3 = 3'(bsel);
    return {8'd0, cnt, c2, en, b3, rd};
  endfunction

  function automatic bit pin_act(input int ch);
    if (merged_m && ch == 0) return dreq_pin[0] == 1'b1;
    return dreq_pin[ch] == req_hi[ch];
  endfunction

  task automatic reset_stats();
    for (int c = 0; c < 2; c++) begin
      acks[c] = 0; rises[c] = 0; run[c] = 0; maxrun[c] = 0; stb[c] = 0;
    end
    owner = -1; purity_err = 0; both_err = 0; pin1_err = 0;
    t_irq0 = -1; t_irq1 = -1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wait_idle();
    int idle = 0;
    for (int i = 0; i < 4000 && idle < 30; i++) begin
      @(posedge clk); #1;
      if (!pin_act(0) && !pin_act(1)) idle++;
      else idle = 0;
    end
  endtask

  // external DMA controller model plus monitors
  always @(negedge clk) begin
    if (rst_n) begin
      for (int ch = 0; ch < 2; ch++) begin
        bit act;
        bit a;
        act = pin_act(ch);
        if (act && !prev_act[ch]) begin
          rises[ch]++; run[ch] = 0;
          if (ch == 0) owner = -1;
        end
        prev_act[ch] = act;
        a = act && (($urandom % 100) < ack_pct);
        if (a) begin
          acks[ch]++; run[ch]++;
          if (run[ch] > maxrun[ch]) maxrun[ch] = run[ch];
        end
        if (merged_m && ch == 1) dack_pin[1] = garbage1 ? 1'($urandom) : 1'b1;
        else if (merged_m)       dack_pin[0] = ~a;
        else                     dack_pin[ch] = ack_hi[ch] ? a : ~a;
      end
      #1;
      for (int s = 0; s < 2; s++) begin
        if (xfer_stb[s]) begin
          stb[s]++;
          if (merged_m) begin
            if (owner < 0) owner = s;
            else if (owner != s) purity_err++;
          end
        end
      end
      if (xfer_stb == 2'b11) both_err++;
      if (merged_m && (dreq_pin[1] != ~req_hi[1])) pin1_err++;
      if (irq[0] && t_irq0 < 0) t_irq0 = cycle;
      if (irq[1] && t_irq1 < 0) t_irq1 = cycle;
      cycle++;
    end
  end

  task automatic run_xfer(input int side, input int code, input int n, input int pct,
                          input bit rd, input int bsel);
    int x;
    reset_stats();
    ack_pct = pct;
    wr(3'd5, 16'h0003);
    wr(3'(2 * side + 1), 16'(n));
    wr(3'(2 * side), mk_cfg(1, code, 1, bsel, rd));
    chk(xfer_rd[side] == rd, "R12 direction out", int'(xfer_rd[side]), int'(rd));
    chk(xfer_buf[side*3 +: 3] == 3'(bsel), "R12 buffer select out",
        int'(xfer_buf[side*3 +: 3]), bsel);
    wait_idle();
    x = (n + 1) / 2;
    chk(acks[side] == x, "R4 transfers for byte count", acks[side], x);
    chk(stb[side] == x, "R12 strobes per transfer", stb[side], x);
    chk(rises[side] == ceil_div(x, beats(code)), "R3 request pulses",
        rises[side], ceil_div(x, beats(code)));
    chk(maxrun[side] <= beats(code), "R3 burst length", maxrun[side], beats(code));
    chk(irq[side] == 1'b1, "R5 flag and interrupt set", int'(irq[side]), 1);
    chk(irq[1-side] == 1'b0, "R11 other output quiet", int'(irq[1-side]), 0);
    wr(3'd4, 16'(1 << side));
    chk(irq[side] == 1'b0, "R5 write-1 clear", int'(irq[side]), 0);
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    reset_stats();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk(dreq_pin == 2'b00, "R1 request pins idle", int'(dreq_pin), 0);
    chk(irq == 2'b00, "R1 interrupts idle", int'(irq), 0);
    chk(xfer_stb == 2'b00, "R1 strobes idle", int'(xfer_stb), 0);

    // R2 timing: request one clock after the enabling write
    reset_stats();
    ack_pct = 100;
    wr(3'd5, 16'h0003);
    wr(3'd1, 16'd7);
    wr(3'd0, mk_cfg(1, 1, 1, 2, 1));
    chk(dreq_pin[0] == 1'b0, "R2 not yet requesting", int'(dreq_pin[0]), 0);
    @(negedge clk); #1;
    chk(dreq_pin[0] == 1'b1, "R2 request after enable", int'(dreq_pin[0]), 1);
    wait_idle();
    chk(acks[0] == 4, "R4 odd count 7", acks[0], 4);
    chk(rises[0] == 1, "R3 single burst of 4", rises[0], 1);
    chk(irq[0] == 1'b1, "R5 flag after count", int'(irq[0]), 1);
    wr(3'd4, 16'h0001);
    chk(irq[0] == 1'b0, "R5 cleared", int'(irq[0]), 0);
    // enable cleared by completion: reloading the count starts nothing
    reset_stats();
    wr(3'd1, 16'd6);
    repeat (12) @(negedge clk);
    chk(rises[0] == 0, "R4 enable cleared on completion", rises[0], 0);

    // R4 zero count
    reset_stats();
    wr(3'd3, 16'd0);
    wr(3'd2, mk_cfg(1, 0, 1, 0, 0));
    repeat (20) @(negedge clk);
    chk(rises[1] == 0, "R4 zero count no request", rises[1], 0);
    wr(3'd2, 16'h0000);

    // constrained random transfers on separate channels
    for (int k = 0; k < 12; k++) begin
      run_xfer(k % 2, int'($urandom % 4), 1 + int'($urandom % 40),
               30 + int'($urandom % 71), 1'($urandom), int'($urandom % 4));
    end

    // R6/R7 counter off, disable during the third burst of 16
    reset_stats();
    ack_pct = 100;
    wr(3'd0, mk_cfg(0, 3, 1, 1, 0));
    for (int i = 0; i < 500 && acks[0] < 35; i++) @(posedge clk);
    wr(3'd0, mk_cfg(0, 3, 0, 1, 0));
    wait_idle();
    chk(acks[0] == 48, "R6 burst completes after disable", acks[0], 48);
    chk(rises[0] == 3, "R7 bursts repeat without counter", rises[0], 3);
    chk(irq[0] == 1'b0, "R6 no flag on disable", int'(irq[0]), 0);

    // R8 polarity: request 0 active low, acknowledge 0 active high
    ack_pct = 0;
    wr(3'd6, 16'h000C);
    req_hi[0] = 1'b0; ack_hi[0] = 1'b1;
    repeat (2) @(negedge clk); #1;
    chk(dreq_pin[0] == 1'b1, "R8 low-active request idles high", int'(dreq_pin[0]), 1);
    run_xfer(0, 0, 10, 100, 0, 3);
    chk(rises[0] == 5, "R8 pulses under inverted polarity", rises[0], 5);
    ack_pct = 0;
    wr(3'd6, 16'h000A);
    req_hi[0] = 1'b1; ack_hi[0] = 1'b0;
    repeat (2) @(negedge clk);

    // R9/R10/R11 merged channel: host arrives during a device burst
    wr(3'd6, 16'h000B);
    merged_m = 1; garbage1 = 1;
    repeat (3) @(negedge clk);
    reset_stats();
    ack_pct = 100;
    wr(3'd5, 16'h0003);
    wr(3'd3, 16'd40);
    wr(3'd2, mk_cfg(1, 2, 1, 0, 1));
    for (int i = 0; i < 500 && stb[1] < 2; i++) @(posedge clk);
    wr(3'd1, 16'd12);
    wr(3'd0, mk_cfg(1, 1, 1, 3, 0));
    wait_idle();
    chk(stb[1] == 20, "R9 device transfers on shared pins", stb[1], 20);
    chk(stb[0] == 6, "R9 host transfers on shared pins", stb[0], 6);
    chk(acks[0] == 26, "R9 total acknowledges channel 0", acks[0], 26);
    chk(rises[0] == 5, "R9 request pulses shared", rises[0], 5);
    chk(pin1_err == 0, "R9 request pin 1 inactive", pin1_err, 0);
    chk(purity_err == 0, "R10 no owner change in a burst", purity_err, 0);
    chk(both_err == 0, "R10 one strobe at a time", both_err, 0);
    chk(t_irq0 >= 0 && t_irq0 < t_irq1, "R10 host served first", t_irq0, t_irq1);
    chk(irq == 2'b11, "R11 both outputs set", int'(irq), 3);
    wr(3'd4, 16'h0002);
    chk(irq == 2'b01, "R11 device flag on output 1 only", int'(irq), 1);
    wr(3'd4, 16'h0001);
    chk(irq == 2'b00, "R5 host flag cleared", int'(irq), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule